// File: doc/BRIEF.md
# Product-Term Cluster Steering Allocator

This block sits between the product-term arrays and the macrocells of a programmable logic fabric. Each cluster input carries the already-ORed result of a small group of product terms. A static configuration assigns every enabled cluster to one macrocell. The allocator forms, for each macrocell, the OR of all clusters legally assigned to it and delivers that sum term to the macrocell.

Reach is limited to a sliding neighbourhood. Macrocell k accepts clusters k-1, k, k+1 and k+2, clipped at both ends of the array. A cluster whose assignment points outside this neighbourhood is dropped from routing and flagged as a configuration error. The path from clusters to sums is purely combinational. The array size is a parameter, and both 12-wide and 16-wide arrays use the same window rule.

Top module: `pt_cluster_steer`

## Requirements
- R1: Each `mcSum[k]` equals the OR of the `clusterIn` bits of every enabled cluster legally steered to macrocell k.
- R2: A macrocell with no legally steered cluster outputs 0. With all enables low, every sum and every error output is 0.
- R3: Cluster c's target field is `clusterTarget[c*IDXW +: IDXW]`, an absolute macrocell index. A target t is legal when c-2 <= t <= c+1, which means macrocell t reaches clusters t-1 to t+2. Targets c+2 and above, and c-3 and below, are illegal.
- R4: Macrocell 0 can draw only from clusters 0, 1 and 2. Cluster 3 targeting macrocell 0 is illegal.
- R5: Macrocell N-1 can draw only from clusters N-2 and N-1. Macrocell N-2 can draw only from clusters N-3, N-2 and N-1.
- R6: An enabled cluster with an illegal target sets `badCluster[c]`, raises `cfgError`, and contributes to no sum.
- R7: A target index of N or above (possible when N is not a power of two) is illegal, with the same effect as R6.
- R8: A disabled cluster contributes to no sum and sets no error flag, whatever its target field holds.
- R9: The same rules hold for N=12 and for N=16.
- R10: The outputs follow the inputs combinationally. A change on the inputs is visible on the outputs in the same cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clusterIn | input | N | Sum-of-product value of each cluster |
| clusterEn | input | N | Per-cluster steering enable |
| clusterTarget | input | N*IDXW | Per-cluster target macrocell index, IDXW bits each |
| mcSum | output | N | Sum term delivered to each macrocell |
| badCluster | output | N | Per-cluster illegal-assignment flag |
| cfgError | output | 1 | OR of all illegal-assignment flags |

## Verification
Immediate assertions run on every input change. They check that each cluster selects at most one window slot, that a flagged cluster drives no slot, and that the edge clusters never select a slot that points off the array. They also check that a high sum always has a high cluster inside its window, and that a disabled cluster never raises an error. Whether a sum equals exactly the right OR, and whether the edge clipping and the N=12 out-of-range targets are judged correctly, can only be shown by the bench. It compares a behavioural model of both array sizes against the design under random and directed configurations.

// File: rtl/pt_steer_pkg.sv
package pt_steer_pkg;
  // Window reach relative to the macrocell index: clusters k-BEHIND .. k+AHEAD
  localparam int BEHIND = 1;
  localparam int AHEAD  = 2;
  localparam int SLOTS  = BEHIND + AHEAD + 1;

  // Control-to-datapath strobes for one cluster.
  // slotHit[j] set: cluster c feeds macrocell c + BEHIND - j.
  typedef struct packed {
    logic [SLOTS-1:0] slotHit;
    logic             bad;
  } steerCtl_t;
endpackage

// File: rtl/pt_steer_ctrl.sv
module pt_steer_ctrl
  import pt_steer_pkg::*;
#(
  parameter int N    = 16,
  parameter int IDXW = $clog2(N)
) (
  input  logic [N-1:0]      clusterEn,
  input  logic [N*IDXW-1:0] clusterTarget,
  output steerCtl_t [N-1:0] strobes
);

  for (genvar c = 0; c < N; c++) begin : g_cl
    logic [IDXW-1:0] tgt;
    steerCtl_t       ctl;
    int              delta;
    logic            legal;

    assign tgt = clusterTarget[c*IDXW +: IDXW];

    always_comb begin
      ctl   = '0;
      delta = int'(tgt) - c;
      legal = (int'(tgt) < N) && (delta >= -AHEAD) && (delta <= BEHIND);
      if (clusterEn[c]) begin
        if (legal) begin
          for (int j = 0; j < SLOTS; j++) begin
            if (delta == BEHIND - j) ctl.slotHit[j] = 1'b1;
          end
        end else begin
          ctl.bad = 1'b1;
        end
      end
    end

    assign strobes[c] = ctl;

    always_comb begin
      AST_ONE_DEST: assert ($onehot0(strobes[c].slotHit))
        else $error("cluster %0d steered to several macrocells", c); // R3
    end
  end

endmodule

// File: rtl/pt_steer_dp.sv
module pt_steer_dp
  import pt_steer_pkg::*;
#(
  parameter int N = 16
) (
  input  logic [N-1:0]      clusterIn,
  input  steerCtl_t [N-1:0] strobes,
  output logic [N-1:0]      mcSum
);

  for (genvar k = 0; k < N; k++) begin : g_mc
    logic [SLOTS-1:0] term;
    localparam int LO = (k - BEHIND < 0) ? 0 : k - BEHIND;
    localparam int HI = (k + AHEAD > N - 1) ? N - 1 : k + AHEAD;

    for (genvar j = 0; j < SLOTS; j++) begin : g_slot
      localparam int SRC = k - BEHIND + j;
      if (SRC >= 0 && SRC < N) begin : g_live
        assign term[j] = clusterIn[SRC] & strobes[SRC].slotHit[j];
      end else begin : g_clip
        assign term[j] = 1'b0;
      end
    end

    assign mcSum[k] = |term;

    always_comb begin
      AST_SUM_NEEDS_SOURCE: assert (!mcSum[k] || (|clusterIn[HI:LO]))
        else $error("macrocell %0d high with no cluster in its window", k); // R1
    end
  end

  for (genvar c = 0; c < N; c++) begin : g_chk
    always_comb begin
      AST_BAD_BLOCKED: assert (!strobes[c].bad || (strobes[c].slotHit == '0))
        else $error("flagged cluster %0d still routed", c); // R6
    end
  end

  always_comb begin
    AST_EDGE_LOW: assert (strobes[0].slotHit[SLOTS-1:BEHIND+1] == '0)
      else $error("cluster 0 routed below macrocell 0"); // R4
    AST_EDGE_HIGH: assert (strobes[N-1].slotHit[BEHIND-1:0] == '0)
      else $error("last cluster routed past last macrocell"); // R5
  end

endmodule

// File: rtl/pt_cluster_steer.sv
module pt_cluster_steer
  import pt_steer_pkg::*;
#(
  parameter int N = 16,
  localparam int IDXW = $clog2(N)
) (
  input  logic [N-1:0]      clusterIn,
  input  logic [N-1:0]      clusterEn,
  input  logic [N*IDXW-1:0] clusterTarget,
  output logic [N-1:0]      mcSum,
  output logic [N-1:0]      badCluster,
  output logic              cfgError
);

  steerCtl_t [N-1:0] strobes;

  pt_steer_ctrl #(.N(N), .IDXW(IDXW)) u_ctrl (
    .clusterEn    (clusterEn),
    .clusterTarget(clusterTarget),
    .strobes      (strobes)
  );

  pt_steer_dp #(.N(N)) u_dp (
    .clusterIn(clusterIn),
    .strobes  (strobes),
    .mcSum    (mcSum)
  );

  for (genvar c = 0; c < N; c++) begin : g_flag
    assign badCluster[c] = strobes[c].bad;
  end

  assign cfgError = |badCluster;

  always_comb begin
    AST_QUIET_WHEN_OFF: assert ((badCluster & ~clusterEn) == '0)
      else $error("disabled cluster raised an error"); // R8
  end

endmodule

// File: tb/pt_cluster_steer_tb.sv
module pt_cluster_steer_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic [15:0] cl, en;
  logic [63:0] tg;
  logic [15:0] sum16, bad16;
  logic [11:0] sum12, bad12;
  logic        err16, err12;
  int total = 0;
  int bad   = 0;
  bit done  = 0;

  pt_cluster_steer #(.N(16)) u_dut (
    .clusterIn(cl), .clusterEn(en), .clusterTarget(tg),
    .mcSum(sum16), .badCluster(bad16), .cfgError(err16));

  pt_cluster_steer #(.N(12)) u_dut12 (
    .clusterIn(cl[11:0]), .clusterEn(en[11:0]), .clusterTarget(tg[47:0]),
    .mcSum(sum12), .badCluster(bad12), .cfgError(err12));

  function automatic void refModel(input int n, input logic [15:0] c_in, e_in,
                                   input logic [63:0] t_in,
                                   output logic [15:0] s_out, output logic [15:0] b_out);
    s_out = '0;
    b_out = '0;
    for (int c = 0; c < n; c++) begin
      if (e_in[c]) begin
        int t = int'(t_in[c*4 +: 4]);
        int d = t - c;
        if (t < n && d >= -2 && d <= 1) s_out[t] = s_out[t] | c_in[c];
        else b_out[c] = 1'b1;
      end
    end
  endfunction

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  function automatic logic [63:0] setT(input logic [63:0] v, input int c, input int t);
    logic [63:0] r = v;
    r[c*4 +: 4] = 4'(t);
    return r;
  endfunction

  // Model comparison on every clock, both sizes
  always @(negedge clk) begin
    if (!rst && !done) begin
      logic [15:0] es, eb;
      refModel(16, cl, en, tg, es, eb);
      chk("R1 sum16", sum16, es);
      chk("R6 bad16", bad16, eb);
      chk("R6 err16", {15'd0, err16}, {15'd0, |eb});
      refModel(12, cl, en, tg, es, eb);
      chk("R9 sum12", {4'd0, sum12}, es);
      chk("R9 bad12", {4'd0, bad12}, eb);
      chk("R9 err12", {15'd0, err12}, {15'd0, |eb});
    end
  end

  task automatic step(input logic [15:0] c_v, input logic [15:0] e_v, input logic [63:0] t_v);
    @(posedge clk);
    cl = c_v; en = e_v; tg = t_v;
    #2;
  endtask

  initial begin
    cl = '0; en = '0; tg = '0;
    repeat (3) @(posedge clk);
    #2;
    chk("R2 reset sum16", sum16, 16'h0);
    chk("R2 reset err16", {15'd0, err16}, 16'h0);
    rst = 1'b0;

    // R4: clusters 0..2 onto macrocell 0, cluster 3 onto 0 is illegal
    step(16'h0008, 16'h000F, 64'h0);
    chk("R4 c3->m0 dropped", sum16, 16'h0);
    chk("R4 c3->m0 flagged", bad16, 16'h0008);
    step(16'h0004, 16'h0007, 64'h0);
    chk("R4 c2->m0 routed", sum16, 16'h0001);
    chk("R4 no error", {15'd0, err16}, 16'h0);

    // R5: last macrocell takes 14,15; 13 illegal. m14 takes 13..15; 12 illegal
    step(16'h2000, 16'h2000, setT(64'h0, 13, 15));
    chk("R5 c13->m15 flagged", bad16, 16'h2000);
    chk("R5 c13->m15 dropped", sum16, 16'h0);
    step(16'h4000, 16'h4000, setT(64'h0, 14, 15));
    chk("R5 c14->m15 routed", sum16, 16'h8000);
    step(16'h2000, 16'h2000, setT(64'h0, 13, 14));
    chk("R5 c13->m14 routed", sum16, 16'h4000);
    step(16'h1000, 16'h1000, setT(64'h0, 12, 14));
    chk("R5 c12->m14 flagged", bad16, 16'h1000);

    // R3: cluster 6 to 7 and 4 legal, 8 and 3 illegal
    step(16'h0040, 16'h0040, setT(64'h0, 6, 7));
    chk("R3 c6->m7", sum16, 16'h0080);
    step(16'h0040, 16'h0040, setT(64'h0, 6, 4));
    chk("R3 c6->m4", sum16, 16'h0010);
    step(16'h0040, 16'h0040, setT(64'h0, 6, 8));
    chk("R3 c6->m8 flagged", bad16, 16'h0040);
    step(16'h0040, 16'h0040, setT(64'h0, 6, 3));
    chk("R3 c6->m3 flagged", bad16, 16'h0040);

    // R7: 12-wide array, cluster 11 targeting 12 is out of range
    step(16'h0800, 16'h0800, setT(64'h0, 11, 12));
    chk("R7 c11->m12 flagged", {4'd0, bad12}, 16'h0800);
    chk("R7 c11->m12 dropped", {4'd0, sum12}, 16'h0);

    // R8: disabled cluster with an illegal target stays silent
    step(16'hFFFF, 16'h0000, 64'hFFFF_FFFF_FFFF_FFFF);
    chk("R8 no error", {15'd0, err16}, 16'h0);
    chk("R8 no sum", sum16, 16'h0);

    // R1: several clusters merged into macrocell 5
    step(16'h0010, 16'h0070, setT(setT(setT(64'h0, 4, 5), 5, 5), 6, 5));
    chk("R1 merge one high", sum16, 16'h0020);

    // R10: change input without a clock edge
    #3 cl = 16'h0000;
    #1 chk("R10 comb fall", sum16, 16'h0);
    cl = 16'h0040;
    #1 chk("R10 comb rise", sum16, 16'h0020);

    // Random configurations, mostly in-window
    for (int i = 0; i < 3000; i++) begin
      logic [63:0] t_v = '0;
      for (int c = 0; c < 16; c++) begin
        int t;
        if ($urandom % 4 == 0) t = int'($urandom % 16);
        else begin
          t = c + int'($urandom % 4) - 2;
          if (t < 0) t = 0;
          if (t > 15) t = 15;
        end
        t_v = setT(t_v, c, t);
      end
      step(16'($urandom), 16'($urandom), t_v);
    end

    @(posedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule